// File: doc/BRIEF.md
# Dual-Buffer Ethernet Frame Receiver

This block is the receive half of a small memory-mapped Ethernet MAC. Frames arrive one byte per clock on a receive interface in the style of MII, framed by a valid strobe, with an error flag that marks a corrupted frame. The block writes each frame into one of two 2 KB capture buffers, ping and pong. A frame is handed to software only when it addresses this station or is a broadcast, ends cleanly and fits in its buffer. The handover works by setting that buffer's done flag.

Software reads a delivered frame out as 32-bit words over a simple register bus. It then writes the buffer's status word with the done bit cleared, which returns the buffer to the receiver. The receiver fills ping first and then alternates between the two buffers. It skips a buffer that software still holds, and it drops a frame when no buffer is free. An interrupt is raised while any held buffer has its interrupt enable set. A parameter removes the pong buffer, and every frame then goes to ping.

Top module: `eth_rx_pingpong`

## Requirements
- R1: After reset, both status words read 0, no buffer is held and `irq` is low.
- R2: The bus address is a 13-bit byte offset. Ping data words start at 0x1000 and its status word is at 0x17FC. Pong data words start at 0x1800 and its status word is at 0x1FFC. Read data and `rdValid` appear exactly one cycle after `busRd`.
- R3: Byte k of a captured frame, counted from 0 on the wire, lands in data word k/4 of its buffer at bits [8*(k%4)+7 : 8*(k%4)]. Every received byte is stored, including the trailing four FCS bytes.
- R4: A frame is delivered only if its first six bytes equal `stationAddr`, with `stationAddr[47:40]` matching the first byte, or are all 0xFF. Any other frame leaves done at 0.
- R5: The done bit of the target buffer (status bit 0) is set on the first clock edge at which `rxValid` is sampled low after a deliverable frame.
- R6: The first delivered frame goes to ping. After each delivered frame the preferred buffer switches to the other one. When the preferred buffer is still held, the frame goes to the other buffer. Frames that are not delivered do not move the preference.
- R7: A frame that starts while every buffer is held is dropped. No buffer content and no status bit changes.
- R8: A status write with bit 0 at 0 clears done. A status write with bit 0 at 1 never sets it. Bit 3 of every status write is stored as the interrupt enable, which reads back in bit 3.
- R9: `irq` is high exactly when some buffer has both done and interrupt enable set.
- R10: A buffer holds at most 2044 frame bytes, because its last word is the status word. A frame of exactly 2044 bytes is delivered. A longer frame is truncated and not delivered.
- R11: A frame during which `rxErr` is high on any byte is not delivered.
- R12: With `PONG_EN` = 0, all frames use ping, the pong status word reads 0, and a frame arriving while ping is held is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxValid | input | 1 | High during every byte of a frame, low between frames |
| rxData | input | 8 | Received byte |
| rxErr | input | 1 | Marks a corrupted byte; the frame is then discarded |
| stationAddr | input | 48 | Station address, bits 47:40 compared with the first byte |
| busAddr | input | 13 | Byte offset of the bus access |
| busRd | input | 1 | Read strobe |
| busWr | input | 1 | Write strobe |
| busWrData | input | 32 | Write data, used only for status words |
| rdData | output | 32 | Read data, valid with rdValid |
| rdValid | output | 1 | Read data valid, one cycle after busRd |
| irq | output | 1 | Receive interrupt |

## Verification
The hardest case to reach is the skip rule. The preferred buffer must still be held by software while the other one is free. That state only arises after a particular history of deliveries and acknowledgements. The stimulus delivers two frames so that both buffers are held and the preference is back on ping. It then acknowledges pong alone and sends a third frame, which must land in pong. Before that, a failed address match and an error-marked frame are sent to show that rejected frames leave the preference where it was. Truncation is reached with frames of 2044 and 2045 bytes, and a second instance without pong shows the drop when its only buffer is held.

// File: rtl/eth_rx_pkg.sv
package eth_rx_pkg;

  // Per-cycle commands from the control to the datapath.
  typedef struct packed {
    logic startFrame;  // first byte of a frame: restart count and filter
    logic storeByte;   // rxData is a frame byte to be stored
    logic bufSel;      // 0 = ping, 1 = pong
  } rxStrobe_t;

  typedef enum logic [1:0] {
    RX_IDLE    = 2'd0,
    RX_CAPTURE = 2'd1,
    RX_DISCARD = 2'd2
  } rxState_t;

  localparam int STAT_DONE_BIT = 0;
  localparam int STAT_IE_BIT   = 3;

endpackage

// File: rtl/eth_rx_dpath.sv
module eth_rx_dpath
  import eth_rx_pkg::*;
#(
  parameter int BUF_BYTES = 2048,
  parameter bit PONG_EN   = 1'b1,
  localparam int ADDR_W   = $clog2(BUF_BYTES) + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         strobe,
  input  logic [7:0]        rxData,
  input  logic [47:0]       stationAddr,
  output logic              dstOk,
  output logic              overflow,
  input  logic [ADDR_W-1:2] rdAddr,
  input  logic              busRd,
  input  logic [31:0]       pingStatus,
  input  logic [31:0]       pongStatus,
  output logic [31:0]       rdData,
  output logic              rdValid
);

  localparam int WORDS     = BUF_BYTES / 4;
  localparam int BUF_AW    = $clog2(BUF_BYTES);
  localparam int CNT_W     = BUF_AW + 1;
  localparam int CAP_BYTES = BUF_BYTES - 4;
  localparam int NBUF      = PONG_EN ? 2 : 1;
  localparam logic [CNT_W-1:0] CAP_CNT  = CNT_W'(CAP_BYTES);
  localparam logic [CNT_W-1:0] ADDR_LEN = CNT_W'(6);

  logic [CNT_W-1:0] byteCnt;
  logic [CNT_W-1:0] idx;
  logic [7:0]       staByte;
  logic             staHit;
  logic             bcHit;
  logic             inCap;

  assign idx   = strobe.startFrame ? '0 : byteCnt;
  assign inCap = (idx < CAP_CNT);

  // Byte counter, saturating one past the capacity.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteCnt <= '0;
    end else if (strobe.storeByte) begin
      if (strobe.startFrame) byteCnt <= CNT_W'(1);
      else if (byteCnt <= CAP_CNT) byteCnt <= byteCnt + CNT_W'(1);
    end
  end

  assign overflow = (byteCnt > CAP_CNT);

  // Destination filter over the first six bytes.
  always_comb begin
    case (idx[2:0])
      3'd0:    staByte = stationAddr[47:40];
      3'd1:    staByte = stationAddr[39:32];
      3'd2:    staByte = stationAddr[31:24];
      3'd3:    staByte = stationAddr[23:16];
      3'd4:    staByte = stationAddr[15:8];
      3'd5:    staByte = stationAddr[7:0];
      default: staByte = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      staHit <= 1'b0;
      bcHit  <= 1'b0;
    end else if (strobe.storeByte && idx < ADDR_LEN) begin
      staHit <= (strobe.startFrame ? 1'b1 : staHit) & (rxData == staByte);
      bcHit  <= (strobe.startFrame ? 1'b1 : bcHit) & (rxData == 8'hFF);
    end
  end

  assign dstOk = (byteCnt >= ADDR_LEN) && (staHit || bcHit);

  // Capture buffers.
  logic [31:0] bufRd [NBUF];

  for (genvar b = 0; b < NBUF; b++) begin : g_buf
    logic [31:0] mem [WORDS];
    always_ff @(posedge clk) begin
      if (strobe.storeByte && strobe.bufSel == 1'(b) && inCap)
        mem[idx[BUF_AW-1:2]][8*idx[1:0] +: 8] <= rxData;
    end
    always_ff @(posedge clk) begin
      if (busRd) bufRd[b] <= mem[rdAddr[BUF_AW-1:2]];
    end
  end

  // Read decode, registered alongside the buffer read.
  logic        rdRegion;
  logic        rdBuf;
  logic        rdIsStat;
  logic [31:0] rdStat;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid  <= 1'b0;
      rdRegion <= 1'b0;
      rdBuf    <= 1'b0;
      rdIsStat <= 1'b0;
      rdStat   <= '0;
    end else begin
      rdValid <= busRd;
      if (busRd) begin
        rdRegion <= rdAddr[ADDR_W-1];
        rdBuf    <= rdAddr[ADDR_W-2];
        rdIsStat <= &rdAddr[BUF_AW-1:2];
        rdStat   <= rdAddr[ADDR_W-2] ? pongStatus : pingStatus;
      end
    end
  end

  always_comb begin
    if (!rdRegion)                   rdData = '0;
    else if (rdIsStat)               rdData = rdStat;
    else if (rdBuf && NBUF > 1)      rdData = bufRd[NBUF-1];
    else if (rdBuf)                  rdData = '0;
    else                             rdData = bufRd[0];
  end

  // R2: read data follows the strobe by one cycle
  assert_read_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    busRd |=> rdValid);

  // R10: once past the capacity, the frame stays truncated until the next start
  assert_overflow_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !strobe.startFrame) |=> overflow);

endmodule

// File: rtl/eth_rx_ctrl.sv
module eth_rx_ctrl
  import eth_rx_pkg::*;
#(
  parameter int BUF_BYTES = 2048,
  parameter bit PONG_EN   = 1'b1,
  localparam int ADDR_W   = $clog2(BUF_BYTES) + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic              rxErr,
  input  logic              dstOk,
  input  logic              overflow,
  input  logic [ADDR_W-1:2] wrAddr,
  input  logic              busWr,
  input  logic              ackBit,
  input  logic              ieBit,
  output rxStrobe_t         strobe,
  output logic [31:0]       pingStatus,
  output logic [31:0]       pongStatus,
  output logic              irq
);

  rxState_t   state;
  logic       curBuf;
  logic       nextBuf;
  logic       errSeen;
  logic [1:0] doneVec;
  logic [1:0] ieVec;
  logic [1:0] setDone;
  logic [1:0] wrStatus;
  logic [1:0] avail;
  logic       anyAvail;
  logic       pick;
  logic       frameOk;

  assign avail[0] = !doneVec[0];
  assign avail[1] = PONG_EN && !doneVec[1];
  assign anyAvail = |avail;

  // Preferred buffer first, the other one if it is held.
  always_comb begin
    if (nextBuf) pick = avail[1] ? 1'b1 : 1'b0;
    else         pick = avail[0] ? 1'b0 : 1'b1;
  end

  assign frameOk = !errSeen && dstOk && !overflow;

  always_comb begin
    strobe  = '0;
    setDone = '0;
    case (state)
      RX_IDLE: begin
        if (rxValid && anyAvail) begin
          strobe.startFrame = 1'b1;
          strobe.storeByte  = 1'b1;
          strobe.bufSel     = pick;
        end
      end
      RX_CAPTURE: begin
        if (rxValid) begin
          strobe.storeByte = 1'b1;
          strobe.bufSel    = curBuf;
        end else if (frameOk) begin
          setDone[curBuf] = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= RX_IDLE;
      curBuf  <= 1'b0;
      nextBuf <= 1'b0;
      errSeen <= 1'b0;
    end else begin
      case (state)
        RX_IDLE: begin
          if (rxValid) begin
            if (anyAvail) begin
              state   <= RX_CAPTURE;
              curBuf  <= pick;
              errSeen <= rxErr;
            end else begin
              state <= RX_DISCARD;
            end
          end
        end
        RX_CAPTURE: begin
          if (rxValid) begin
            errSeen <= errSeen | rxErr;
          end else begin
            state <= RX_IDLE;
            if (frameOk) nextBuf <= PONG_EN ? ~curBuf : 1'b0;
          end
        end
        default: begin
          if (!rxValid) state <= RX_IDLE;
        end
      endcase
    end
  end

  // Status words: done set by the receiver, cleared only by software.
  logic isStatWr;
  assign isStatWr    = busWr && wrAddr[ADDR_W-1] && (&wrAddr[ADDR_W-3:2]);
  assign wrStatus[0] = isStatWr && !wrAddr[ADDR_W-2];
  assign wrStatus[1] = isStatWr && wrAddr[ADDR_W-2];

  for (genvar b = 0; b < 2; b++) begin : g_stat
    if (b == 0 || PONG_EN) begin : g_live
      always_ff @(posedge clk) begin
        if (!rstN) begin
          doneVec[b] <= 1'b0;
          ieVec[b]   <= 1'b0;
        end else begin
          if (setDone[b])                   doneVec[b] <= 1'b1;
          else if (wrStatus[b] && !ackBit)  doneVec[b] <= 1'b0;
          if (wrStatus[b])                  ieVec[b]   <= ieBit;
        end
      end
    end else begin : g_absent
      assign doneVec[b] = 1'b0;
      assign ieVec[b]   = 1'b0;
    end
  end

  always_comb begin
    pingStatus = '0;
    pongStatus = '0;
    pingStatus[STAT_DONE_BIT] = doneVec[0];
    pingStatus[STAT_IE_BIT]   = ieVec[0];
    pongStatus[STAT_DONE_BIT] = doneVec[1];
    pongStatus[STAT_IE_BIT]   = ieVec[1];
  end

  assign irq = |(doneVec & ieVec);

  // R6: bytes are never written into a buffer that software holds
  assert_target_free_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.storeByte |-> !doneVec[strobe.bufSel]);

  // R5: ping done rises only at the end of a ping capture
  assert_done_at_end_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneVec[0]) |-> $past(state == RX_CAPTURE && !rxValid && curBuf == 1'b0));

  // R7: a frame starting with all buffers held is discarded
  assert_drop_when_full_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == RX_IDLE && rxValid && !anyAvail) |=> state == RX_DISCARD);

  // R12: without pong, pong is never handed out
  assert_no_pong_R12: assert property (@(posedge clk) disable iff (!rstN)
    !PONG_EN |-> !(strobe.storeByte && strobe.bufSel));

endmodule

// File: rtl/eth_rx_pingpong.sv
module eth_rx_pingpong
  import eth_rx_pkg::*;
#(
  parameter int BUF_BYTES = 2048,
  parameter bit PONG_EN   = 1'b1,
  localparam int ADDR_W   = $clog2(BUF_BYTES) + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic [7:0]        rxData,
  input  logic              rxErr,
  input  logic [47:0]       stationAddr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [31:0]       busWrData,
  output logic [31:0]       rdData,
  output logic              rdValid,
  output logic              irq
);

  rxStrobe_t   strobe;
  logic        dstOk;
  logic        overflow;
  logic [31:0] pingStatus;
  logic [31:0] pongStatus;
  logic        unusedBits;

  assign unusedBits = ^{busAddr[1:0], busWrData[31:4], busWrData[2:1]};

  eth_rx_ctrl #(.BUF_BYTES(BUF_BYTES), .PONG_EN(PONG_EN)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .rxValid    (rxValid),
    .rxErr      (rxErr),
    .dstOk      (dstOk),
    .overflow   (overflow),
    .wrAddr     (busAddr[ADDR_W-1:2]),
    .busWr      (busWr),
    .ackBit     (busWrData[STAT_DONE_BIT]),
    .ieBit      (busWrData[STAT_IE_BIT]),
    .strobe     (strobe),
    .pingStatus (pingStatus),
    .pongStatus (pongStatus),
    .irq        (irq)
  );

  eth_rx_dpath #(.BUF_BYTES(BUF_BYTES), .PONG_EN(PONG_EN)) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .rxData      (rxData),
    .stationAddr (stationAddr),
    .dstOk       (dstOk),
    .overflow    (overflow),
    .rdAddr      (busAddr[ADDR_W-1:2]),
    .busRd       (busRd),
    .pingStatus  (pingStatus),
    .pongStatus  (pongStatus),
    .rdData      (rdData),
    .rdValid     (rdValid)
  );

endmodule

// File: tb/eth_rx_pingpong_bench.sv
`timescale 1ns/1ps
module eth_rx_pingpong_bench;

  localparam logic [12:0] PING    = 13'h1000;
  localparam logic [12:0] PING_ST = 13'h17FC;
  localparam logic [12:0] PONG    = 13'h1800;
  localparam logic [12:0] PONG_ST = 13'h1FFC;
  localparam logic [47:0] STA     = 48'h02_11_22_33_44_55;
  localparam logic [47:0] BCAST   = 48'hFF_FF_FF_FF_FF_FF;
  localparam logic [47:0] OTHER   = 48'h02_11_22_33_44_56;

  typedef logic [7:0] bq_t[$];
  typedef struct {
    logic [12:0] addr;
    logic [31:0] exp;
    bit          single;
    string       tag;
  } rdItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxValid = 1'b0;
  logic [7:0]  rxData = 8'h00;
  logic        rxErr = 1'b0;
  logic [12:0] busAddr = '0;
  logic        busRd = 1'b0;
  logic        busWr = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] rdData, rdDataS;
  logic        rdValid, rdValidS, irq, irqS;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  rdItem_t rdQ[$];

  always #10 clk = ~clk;

  eth_rx_pingpong #(.PONG_EN(1'b1)) u_eth_rx_pingpong (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxData(rxData), .rxErr(rxErr),
    .stationAddr(STA), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busWrData(busWrData), .rdData(rdData), .rdValid(rdValid), .irq(irq));

  eth_rx_pingpong #(.PONG_EN(1'b0)) u_single (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxData(rxData), .rxErr(rxErr),
    .stationAddr(STA), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busWrData(busWrData), .rdData(rdDataS), .rdValid(rdValidS), .irq(irqS));

  task automatic checkVal(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: compares each read result with the oldest expected item.
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (rdQ.size() == 0) begin
        checkVal("R2 unexpected read data", 32'h1, 32'h0);
      end else begin
        rdItem_t it;
        it = rdQ.pop_front();
        checkVal(it.tag, it.single ? rdDataS : rdData, it.exp);
      end
    end
  end

  task automatic busRead(logic [12:0] a, logic [31:0] exp, bit single, string tag);
    rdItem_t it;
    @(negedge clk);
    it.addr = a; it.exp = exp; it.single = single; it.tag = tag;
    rdQ.push_back(it);
    busAddr = a;
    busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic busWrite(logic [12:0] a, logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  function automatic bq_t mkFrame(logic [47:0] dst, int len, logic [7:0] seed);
    bq_t f;
    for (int i = 0; i < len; i++) begin
      if (i < 6) f.push_back(dst[47-8*i -: 8]);
      else f.push_back(seed + 8'(i * 7));
    end
    return f;
  endfunction

  task automatic sendFrame(bq_t f, int errAt);
    for (int i = 0; i < f.size(); i++) begin
      @(negedge clk);
      rxValid = 1'b1; rxData = f[i]; rxErr = (i == errAt);
    end
    @(negedge clk);
    rxValid = 1'b0; rxErr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [31:0] wordOf(bq_t f, int w);
    return {f[4*w+3], f[4*w+2], f[4*w+1], f[4*w]};
  endfunction

  task automatic expectWords(logic [12:0] base, bq_t f, int n, bit single, string tag);
    for (int w = 0; w < n; w++)
      busRead(base + 13'(4 * w), wordOf(f, w), single, tag);
  endtask

  task automatic finish();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    bq_t fa, fb, fc, fd, fe, ff, fg, fh, fBig, fOver;
    fa = mkFrame(STA, 20, 8'h10);
    fb = mkFrame(BCAST, 16, 8'h40);
    fc = mkFrame(STA, 12, 8'h70);
    fd = mkFrame(OTHER, 16, 8'h90);
    fe = mkFrame(STA, 16, 8'hA0);
    ff = mkFrame(STA, 16, 8'hB0);
    fg = mkFrame(BCAST, 16, 8'hC0);
    fh = mkFrame(STA, 16, 8'hD0);
    fBig  = mkFrame(STA, 2044, 8'h21);
    fOver = mkFrame(STA, 2045, 8'h33);

    repeat (5) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    busRead(PING_ST, 32'h0, 0, "R1 ping status after reset");
    busRead(PONG_ST, 32'h0, 0, "R1 pong status after reset");
    @(negedge clk); checkVal("R1 irq after reset", irq, 0);

    // R8 interrupt enable stored and read back
    busWrite(PING_ST, 32'h8);
    busWrite(PONG_ST, 32'h8);
    busRead(PING_ST, 32'h8, 0, "R8 ping ie readback");
    busRead(PONG_ST, 32'h8, 0, "R8 pong ie readback");
    @(negedge clk); checkVal("R9 irq low with nothing held", irq, 0);

    // R3 R4 R5 R6: station frame into ping, FCS bytes included
    sendFrame(fa, -1);
    busRead(PING_ST, 32'h9, 0, "R5 ping done after frame A");
    busRead(PONG_ST, 32'h8, 0, "R6 pong untouched by frame A");
    expectWords(PING, fa, 5, 0, "R3 frame A words in ping");
    @(negedge clk); checkVal("R9 irq with ping held", irq, 1);
    busRead(PING_ST, 32'h9, 1, "R12 single ping done after A");

    // R4 broadcast into pong, R6 alternation; R12 single drops it
    sendFrame(fb, -1);
    busRead(PONG_ST, 32'h9, 0, "R4 R6 broadcast frame B done in pong");
    expectWords(PONG, fb, 4, 0, "R3 frame B words in pong");
    busRead(PING, wordOf(fa, 0), 1, "R12 single ping kept frame A");
    busRead(PONG_ST, 32'h0, 1, "R12 single pong status reads 0");

    // R7 both held: frame C dropped
    sendFrame(fc, -1);
    busRead(PING, wordOf(fa, 0), 0, "R7 ping content kept");
    busRead(PONG, wordOf(fb, 0), 0, "R7 pong content kept");
    busRead(PING_ST, 32'h9, 0, "R7 ping status kept");
    busRead(PONG_ST, 32'h9, 0, "R7 pong status kept");

    // R8 ack, R9 irq follows
    busWrite(PING_ST, 32'h8);
    busRead(PING_ST, 32'h8, 0, "R8 ack clears ping done");
    @(negedge clk); checkVal("R9 irq while pong held", irq, 1);
    busWrite(PONG_ST, 32'h8);
    @(negedge clk); checkVal("R9 irq after both acked", irq, 0);
    busWrite(PING_ST, 32'h9);
    busRead(PING_ST, 32'h8, 0, "R8 writing done=1 does not set it");

    // R4 mismatch, R11 error: not delivered, preference unmoved
    sendFrame(fd, -1);
    busRead(PING_ST, 32'h8, 0, "R4 foreign destination not done");
    sendFrame(fe, 10);
    busRead(PING_ST, 32'h8, 0, "R11 error frame not done");
    busRead(PONG_ST, 32'h8, 0, "R11 pong untouched");

    // R6 preference still ping, then alternation, then skip
    sendFrame(ff, -1);
    busRead(PING_ST, 32'h9, 0, "R6 frame F in ping after rejects");
    sendFrame(fg, -1);
    busRead(PONG_ST, 32'h9, 0, "R6 frame G in pong");
    busWrite(PONG_ST, 32'h8);
    sendFrame(fh, -1);
    busRead(PONG_ST, 32'h9, 0, "R6 held ping skipped, H in pong");
    busRead(PONG + 13'd12, wordOf(fh, 3), 0, "R6 frame H word 3");
    busRead(PING, wordOf(ff, 0), 0, "R6 ping still frame F");

    // R10 capacity boundary
    busWrite(PING_ST, 32'h8);
    busWrite(PONG_ST, 32'h8);
    sendFrame(fOver, -1);
    busRead(PING_ST, 32'h8, 0, "R10 2045-byte frame not done");
    busRead(PONG_ST, 32'h8, 0, "R10 pong untouched by long frame");
    sendFrame(fBig, -1);
    busRead(PING_ST, 32'h9, 0, "R10 2044-byte frame done");
    busRead(PING + 13'(4 * 510), wordOf(fBig, 510), 0, "R10 last data word");
    busRead(PING, wordOf(fBig, 0), 0, "R10 first data word");

    repeat (4) @(negedge clk);
    checkVal("R2 all reads answered", 32'(rdQ.size()), 32'h0);
    finish();
  end

endmodule